// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block runs the start-up sequence of a processor core. While the synchronous reset is high, it forces the status control bits to a known state. These are supervisor mode on, tracing off and all interrupt mask bits set. When reset falls, the block fetches the start-up vectors from the bottom of memory. It makes four 16-bit word reads through a simple request/acknowledge read port.

The first two words form the 32-bit initial supervisor stack pointer, high word first. The next two words form the 32-bit initial program counter, also high word first. When all four words are in, a done flag tells the fetch unit that instruction fetch may start. Any reset during the sequence abandons it. The sequence starts again from the first word when reset is released.

Top module: `rstvec_seq`

## Requirements
- R1: While `rst` is sampled high, the next cycle shows `sup_o`=1, `trace_o`=0 and `imask_o`=3'b111. After reset these three outputs keep their values until the next reset.
- R2: While `rst` is sampled high, the next cycle shows `rd_req_o`=0, `boot_done_o`=0, and `ssp_o` and `pc_o` cleared to zero.
- R3: The first request is raised on the first clock edge at which `rst` is sampled low. Requests are issued in the fixed order of byte addresses 0x000000, 0x000002, 0x000004 and 0x000006.
- R4: A raised request holds `rd_req_o` high and `rd_addr_o` stable until an edge where `rd_ack_i` is high. `rd_data_i` is taken on that edge.
- R5: After each accepted word, `rd_req_o` is low for exactly one cycle before the next request rises.
- R6: `ssp_o` equals {word at 0x000000, word at 0x000002}. `pc_o` equals {word at 0x000004, word at 0x000006}.
- R7: `boot_done_o` rises one cycle after the edge that takes the fourth word. It then stays high, with no further requests, until the next reset.
- R8: A reset during the sequence aborts it, even when it coincides with an acknowledge. After release, the sequence restarts at address 0x000000, and `boot_done_o` stays low until four new words are taken.
- R9: `rd_ack_i` is ignored while no request is pending. This covers the one-cycle gap between requests and the time after done. `ssp_o` and `pc_o` do not change and the sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | 24 | Byte address of the requested word |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 16 | Read data word |
| ssp_o | output | 32 | Initial supervisor stack pointer |
| pc_o | output | 32 | Initial program counter |
| sup_o | output | 1 | Supervisor mode bit |
| trace_o | output | 1 | Trace enable bit |
| imask_o | output | 3 | Interrupt mask level |
| boot_done_o | output | 1 | Vectors loaded, fetch may begin |

## Verification
Two events can collide in one cycle. The first collision is a reset arriving on the same edge as an acknowledge. The bench raises `rst` and `rd_ack_i` together while a request is pending, with a marker data word. It then judges that the request drops, the vectors read zero, and the next run starts again at address 0 without the marker word in either vector.

The second collision is an acknowledge left high into the gap cycle, where the next request is being launched. The bench holds `rd_ack_i` high with a different marker word and checks that it is discarded. The final vectors must carry only the words given under a pending request.

// File: rtl/rstvec_pkg.sv
package rstvec_pkg;
  typedef enum logic [1:0] {
    SQ_LAUNCH = 2'd0,
    SQ_WAIT   = 2'd1,
    SQ_FIN    = 2'd2,
    SQ_DONE   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rstvec_status.sv
module rstvec_status #(
  parameter int IMASK_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  output logic               sup_o,
  output logic               trace_o,
  output logic [IMASK_W-1:0] imask_o
);
  // Reset forces the control bits; other core logic (outside) owns later updates.
  always_ff @(posedge clk) begin
    if (rst) begin
      sup_o   <= 1'b1;
      trace_o <= 1'b0;
      imask_o <= '1;
    end
  end

  a_r1_reset_status: assert property (@(posedge clk)
    rst |=> (sup_o && !trace_o && (&imask_o)));

  a_r1_status_hold: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($stable(sup_o) && $stable(trace_o) && $stable(imask_o)));
endmodule

// File: rtl/rstvec_ctrl.sv
module rstvec_ctrl
  import rstvec_pkg::*;
#(
  parameter int                 ADDR_W   = 24,
  parameter int                 DATA_W   = 16,
  parameter int                 NWORDS   = 4,
  parameter logic [ADDR_W-1:0]  VEC_BASE = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_ack_i,
  output logic                        rd_req_o,
  output logic [ADDR_W-1:0]           rd_addr_o,
  output logic                        cap_en_o,
  output logic [$clog2(NWORDS)-1:0]   cap_idx_o,
  output logic                        done_o
);
  localparam int IDX_W      = $clog2(NWORDS);
  localparam int ADDR_SHIFT = $clog2(DATA_W / 8);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  seq_state_t       state_q;
  logic [IDX_W-1:0] idx_q;

  // An acknowledge counts only while a request is outstanding.
  assign cap_en_o  = (state_q == SQ_WAIT) && rd_ack_i;
  assign cap_idx_o = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_LAUNCH;
      idx_q     <= '0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= VEC_BASE;
      done_o    <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_LAUNCH: begin
          rd_req_o  <= 1'b1;
          rd_addr_o <= VEC_BASE + (ADDR_W'(idx_q) << ADDR_SHIFT);
          state_q   <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (rd_ack_i) begin
            rd_req_o <= 1'b0;
            if (idx_q == LAST_IDX) begin
              state_q <= SQ_FIN;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= SQ_LAUNCH;
            end
          end
        end
        SQ_FIN: begin
          done_o  <= 1'b1;
          state_q <= SQ_DONE;
        end
        SQ_DONE: begin
          done_o <= 1'b1;
        end
        default: state_q <= SQ_LAUNCH;
      endcase
    end
  end

  a_r2_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rd_req_o && !done_o));

  a_r3_addr_aligned: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> (rd_addr_o[0] == 1'b0));

  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  a_r5_gap_after_ack: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && rd_ack_i) |=> !rd_req_o);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  a_r7_no_req_when_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !rd_req_o);
endmodule

// File: rtl/rstvec_words.sv
module rstvec_words #(
  parameter int DATA_W = 16,
  parameter int VEC_W  = 32,
  parameter int NVEC   = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cap_en_i,
  input  logic [$clog2(NVEC*VEC_W/DATA_W)-1:0] cap_idx_i,
  input  logic [DATA_W-1:0]               data_i,
  output logic [NVEC*VEC_W-1:0]           vecs_o
);
  localparam int WPV    = VEC_W / DATA_W;
  localparam int NWORDS = NVEC * WPV;

  logic [DATA_W-1:0] word_q [NWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) word_q[i] <= '0;
    end else if (cap_en_i) begin
      word_q[cap_idx_i] <= data_i;
    end
  end

  // Vector v: its first-read word lands in the most significant slice.
  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    for (genvar j = 0; j < WPV; j++) begin : g_word
      assign vecs_o[v*VEC_W + VEC_W - 1 - j*DATA_W -: DATA_W] = word_q[v*WPV + j];
    end
  end

  a_r9_hold_without_capture: assert property (@(posedge clk) disable iff (rst)
    !cap_en_i |=> $stable(vecs_o));
endmodule

// File: rtl/rstvec_seq.sv
module rstvec_seq #(
  parameter int                ADDR_W   = 24,
  parameter int                DATA_W   = 16,
  parameter int                VEC_W    = 32,
  parameter int                IMASK_W  = 3,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic               clk,
  input  logic               rst,
  output logic               rd_req_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic               rd_ack_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic [VEC_W-1:0]   ssp_o,
  output logic [VEC_W-1:0]   pc_o,
  output logic               sup_o,
  output logic               trace_o,
  output logic [IMASK_W-1:0] imask_o,
  output logic               boot_done_o
);
  localparam int NVEC   = 2;
  localparam int NWORDS = NVEC * (VEC_W / DATA_W);
  localparam int IDX_W  = $clog2(NWORDS);

  logic             cap_en;
  logic [IDX_W-1:0] cap_idx;
  logic [NVEC*VEC_W-1:0] vecs;

  rstvec_status #(.IMASK_W(IMASK_W)) status_i (
    .clk     (clk),
    .rst     (rst),
    .sup_o   (sup_o),
    .trace_o (trace_o),
    .imask_o (imask_o)
  );

  rstvec_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NWORDS   (NWORDS),
    .VEC_BASE (VEC_BASE)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .rd_ack_i  (rd_ack_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .cap_en_o  (cap_en),
    .cap_idx_o (cap_idx),
    .done_o    (boot_done_o)
  );

  rstvec_words #(
    .DATA_W (DATA_W),
    .VEC_W  (VEC_W),
    .NVEC   (NVEC)
  ) words_i (
    .clk       (clk),
    .rst       (rst),
    .cap_en_i  (cap_en),
    .cap_idx_i (cap_idx),
    .data_i    (rd_data_i),
    .vecs_o    (vecs)
  );

  // Vector 0 is the stack pointer, vector 1 the program counter.
  assign ssp_o = vecs[0 +: VEC_W];
  assign pc_o  = vecs[VEC_W +: VEC_W];
endmodule

// File: tb/rstvec_seq_tb_top.sv
module rstvec_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic [31:0] ssp, pc;
  logic        sup, trace, done;
  logic [2:0]  imask;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstvec_seq dut_i (
    .clk (clk), .rst (rst),
    .rd_req_o (rd_req), .rd_addr_o (rd_addr),
    .rd_ack_i (rd_ack), .rd_data_i (rd_data),
    .ssp_o (ssp), .pc_o (pc),
    .sup_o (sup), .trace_o (trace), .imask_o (imask),
    .boot_done_o (done)
  );

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic check_status(input string ctx);
    chk(sup == 1'b1,      "R1", {ctx, " sup"},   64'(sup),   64'd1);
    chk(trace == 1'b0,    "R1", {ctx, " trace"}, 64'(trace), 64'd0);
    chk(imask == 3'b111,  "R1", {ctx, " imask"}, 64'(imask), 64'd7);
  endtask

  task automatic hold_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    rd_ack = 1'b0;
    repeat (n) @(negedge clk);
    check_status("in reset");
    chk(!rd_req, "R2", "req in reset",  64'(rd_req), 64'd0);
    chk(!done,   "R2", "done in reset", 64'(done),   64'd0);
    chk(ssp == 32'd0 && pc == 32'd0, "R2", "vectors cleared", {ssp, pc}, 64'd0);
  endtask

  // Release reset and check the first request (R3).
  task automatic release_reset();
    rst = 1'b0;
    @(negedge clk);
    chk(rd_req == 1'b1,     "R3", "first req after release", 64'(rd_req), 64'd1);
    chk(rd_addr == 24'h0,   "R3", "first address",           64'(rd_addr), 64'd0);
  endtask

  // Serve one request; entered at a negedge.
  task automatic serve(input logic [23:0] exp_addr, input logic [15:0] word,
                       input int wait_n, input bit spur, input bit last);
    int guard = 0;
    while (!rd_req && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk(rd_req == 1'b1,     "R3", "request present", 64'(rd_req), 64'd1);
    chk(rd_addr == exp_addr, "R3", "request order",  64'(rd_addr), 64'(exp_addr));
    for (int k = 0; k < wait_n; k++) begin
      @(negedge clk);
      chk(rd_req == 1'b1 && rd_addr == exp_addr, "R4", "req held while waiting",
          {39'd0, rd_req, rd_addr}, {39'd0, 1'b1, exp_addr});
    end
    rd_ack  = 1'b1;
    rd_data = word;
    @(negedge clk);
    chk(rd_req == 1'b0, "R5", "req low after ack", 64'(rd_req), 64'd0);
    if (last) chk(done == 1'b0, "R7", "done not yet", 64'(done), 64'd0);
    if (spur) rd_data = 16'hDEAD;   // R9: ack stays high into the gap
    else      rd_ack  = 1'b0;
    @(negedge clk);
    rd_ack = 1'b0;
    if (last) begin
      chk(done == 1'b1,   "R7", "done one cycle after last word", 64'(done), 64'd1);
      chk(rd_req == 1'b0, "R7", "no req after done", 64'(rd_req), 64'd0);
    end else begin
      chk(rd_req == 1'b1 && rd_addr == exp_addr + 24'd2, "R5", "one-cycle gap then next req",
          {39'd0, rd_req, rd_addr}, {39'd0, 1'b1, exp_addr + 24'd2});
    end
  endtask

  task automatic run_full(input logic [15:0] w0, w1, w2, w3,
                          input int wt, input bit spur, input string ctx);
    release_reset();
    serve(24'h0, w0, wt,     spur, 1'b0);
    serve(24'h2, w1, wt + 1, 1'b0, 1'b0);
    serve(24'h4, w2, wt,     spur, 1'b0);
    serve(24'h6, w3, wt + 2, spur, 1'b1);
    chk(ssp == {w0, w1}, "R6", {ctx, " ssp"}, 64'(ssp), 64'({w0, w1}));
    chk(pc  == {w2, w3}, "R6", {ctx, " pc"},  64'(pc),  64'({w2, w3}));
  endtask

  task automatic t_reset_state();
    hold_reset(3);
  endtask

  task automatic t_basic();
    run_full(16'h0020, 16'h0128, 16'h003F, 16'h1420, 0, 1'b0, "basic");
    check_status("after basic");
  endtask

  task automatic t_ack_after_done();
    logic [31:0] s0 = ssp, p0 = pc;
    for (int k = 0; k < 3; k++) begin
      rd_ack  = 1'b1;
      rd_data = 16'hBEEF;
      @(negedge clk);
      chk(rd_req == 1'b0, "R7", "no req while done", 64'(rd_req), 64'd0);
    end
    rd_ack = 1'b0;
    @(negedge clk);
    chk(ssp == s0 && pc == p0, "R9", "ack after done ignored", {ssp, pc}, {s0, p0});
    chk(done == 1'b1, "R7", "done sticky", 64'(done), 64'd1);
    check_status("after stray acks");
  endtask

  task automatic t_waits_and_gap_acks();
    hold_reset(2);
    run_full(16'hA5A5, 16'h5A5A, 16'h1234, 16'hFEDC, 2, 1'b1, "waits+gap ack");
  endtask

  task automatic t_abort();
    hold_reset(2);
    release_reset();
    serve(24'h0, 16'h1111, 1, 1'b0, 1'b0);
    serve(24'h2, 16'h2222, 0, 1'b0, 1'b0);
    // R8: reset on the same edge as an acknowledge of the third word.
    rst     = 1'b1;
    rd_ack  = 1'b1;
    rd_data = 16'h7777;
    @(negedge clk);
    rd_ack = 1'b0;
    chk(rd_req == 1'b0, "R8", "abort drops req",  64'(rd_req), 64'd0);
    chk(done == 1'b0,   "R8", "abort keeps done low", 64'(done), 64'd0);
    chk(ssp == 32'd0 && pc == 32'd0, "R8", "abort clears vectors", {ssp, pc}, 64'd0);
    @(negedge clk);
    run_full(16'h0BAD, 16'hC0DE, 16'h4242, 16'h9999, 1, 1'b0, "restart");
    check_status("after restart");
  endtask

  initial begin
    t_reset_state();
    t_basic();
    t_ack_after_done();
    t_waits_and_gap_acks();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule